// File: doc/BRIEF.md
# Event-Triggered Thread Switch Controller

This block decides which hardware thread context of a block-interleaved multithreaded in-order core owns the pipeline. The chosen thread runs until a switch event occurs. Five trigger sources are available, and each has its own enable bit: an explicit switch instruction, fetch of an instruction of a selected class (memory or branch), a data-cache miss reported from a later stage, a read of a register whose load is still outstanding, and an external signal such as an interrupt.

The block holds one valid bit for each architectural register of each thread. A load issue clears the bit and the load's data return sets it again, so the block can wait until a pending register is actually read before it switches. When a switch fires, the next thread is picked round-robin starting after the active thread. Threads that are not ready, or that still have a load outstanding, are skipped. In the cycle after the trigger the block pulses a switch strobe and a flush of the outgoing thread's younger instructions, and it records the restart PC of that thread.

Top module: `tswitch_ctrl`

## Requirements
- R1: After reset, thread 0 is active and `sw_strobe` and `flush` are low. While no enabled trigger is present, `act_thr` does not change.
- R2: `sw_instr` causes a switch when `pol_en` bit 0 is set. When that bit is clear, `sw_instr` has no effect.
- R3: `pol_en` bit 1 enables the fetch-class trigger. With `cls_sel`=0 only `fetch_mem` triggers. With `cls_sel`=1 only `fetch_br` triggers.
- R4: `dmiss` causes a switch when `pol_en` bit 2 is set.
- R5: `ext_sig` causes a switch when `pol_en` bit 4 is set.
- R6: Every register valid bit is set at reset. A load issue clears the bit for its thread and register, and a load return sets it. If an issue and a return hit the same bit in the same cycle, the issue wins.
- R7: With `pol_en` bit 3 set, a switch occurs when `rd_vld` reads a register of the active thread whose valid bit is clear. Issuing the load does not itself switch, and reading a valid register does not switch.
- R8: The new thread is the first thread, counting upward from active+1 modulo the thread count, that has `thr_ready` high and no cleared valid bit.
- R9: If an enabled trigger occurs and no other thread qualifies, `act_thr` stays the same and no strobe or flush is raised.
- R10: A switch raises `sw_strobe` and `flush` for exactly one cycle after the trigger edge. In the same cycle it updates `act_thr` and loads `restart_pc` with the `cur_pc` that was present at the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pol_en | input | 5 | Trigger enables: bit0 explicit, bit1 fetch class, bit2 cache miss, bit3 use, bit4 external |
| cls_sel | input | 1 | Fetch class: 0 memory, 1 branch |
| sw_instr | input | 1 | Explicit switch instruction at trigger point |
| fetch_mem | input | 1 | Memory instruction fetched |
| fetch_br | input | 1 | Branch instruction fetched |
| dmiss | input | 1 | Data-cache miss from later stage |
| ext_sig | input | 1 | External switch request |
| rd_vld | input | 1 | Active thread reads a register |
| rd_reg | input | log2(NREG) | Register being read |
| ld_iss | input | 1 | Load issued |
| ld_iss_thr | input | log2(NTHR) | Thread of issued load |
| ld_iss_reg | input | log2(NREG) | Destination of issued load |
| ld_ret | input | 1 | Load data returned |
| ld_ret_thr | input | log2(NTHR) | Thread of returned load |
| ld_ret_reg | input | log2(NREG) | Destination of returned load |
| thr_ready | input | NTHR | Per-thread ready status |
| cur_pc | input | PCW | PC of the instruction at the trigger point |
| act_thr | output | log2(NTHR) | Active thread |
| sw_strobe | output | 1 | One-cycle switch pulse |
| flush | output | 1 | One-cycle flush of the outgoing thread |
| restart_pc | output | PCW | Restart PC of the outgoing thread |

## Verification
Every output comes from a register, so any trigger, ready mask or load event driven before a clock edge shows up at the ports exactly one edge later. The bench drives inputs on the falling edge and checks at the next falling edge. A valid bit changed by a load event affects triggering and selection one edge after that event, so the bench lets one cycle pass between a load issue or return and the read or switch that depends on it. The round-robin sweep runs a trigger in every cycle and compares each result with the pick computed by the bench for the previous cycle's active thread and ready mask.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int P_EXPL  = 0;
  localparam int P_CLASS = 1;
  localparam int P_MISS  = 2;
  localparam int P_USE   = 3;
  localparam int P_EXT   = 4;
  localparam int NPOL    = 5;

  typedef enum logic {CLS_MEM = 1'b0, CLS_BR = 1'b1} fetch_cls_e;
endpackage

// File: rtl/tsw_scoreboard.sv
module tsw_scoreboard #(
  parameter int NTHR = 4,
  parameter int NREG = 8,
  localparam int TW = $clog2(NTHR),
  localparam int RW = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_iss,
  input  logic [TW-1:0]      ld_iss_thr,
  input  logic [RW-1:0]      ld_iss_reg,
  input  logic               ld_ret,
  input  logic [TW-1:0]      ld_ret_thr,
  input  logic [RW-1:0]      ld_ret_reg,
  input  logic [TW-1:0]      rd_thr,
  input  logic [RW-1:0]      rd_reg,
  output logic               rd_pend,
  output logic [NTHR-1:0]    pend_any,
  output logic [NTHR*NREG-1:0] vld_flat
);
  logic [NREG-1:0] vld [NTHR];

  always_ff @(posedge clk) begin
    for (int t = 0; t < NTHR; t++) begin
      for (int r = 0; r < NREG; r++) begin
        if (!rst_n)
          vld[t][r] <= 1'b1;
        else if (ld_iss && ld_iss_thr == TW'(t) && ld_iss_reg == RW'(r))
          vld[t][r] <= 1'b0;
        else if (ld_ret && ld_ret_thr == TW'(t) && ld_ret_reg == RW'(r))
          vld[t][r] <= 1'b1;
      end
    end
  end

  assign rd_pend = ~vld[rd_thr][rd_reg];

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    assign pend_any[t] = ~&vld[t];
    assign vld_flat[t*NREG +: NREG] = vld[t];
  end
endmodule

// File: rtl/tsw_trigger.sv
module tsw_trigger
  import tsw_pkg::*;
(
  input  logic            cls_sel,
  input  logic [NPOL-1:0] pol_en,
  input  logic            sw_instr,
  input  logic            fetch_mem,
  input  logic            fetch_br,
  input  logic            dmiss,
  input  logic            ext_sig,
  input  logic            rd_vld,
  input  logic            rd_pend,
  output logic [NPOL-1:0] trig_vec,
  output logic            trig_any
);
  logic [NPOL-1:0] raw;

  always_comb begin
    raw          = '0;
    raw[P_EXPL]  = sw_instr;
    raw[P_CLASS] = (fetch_cls_e'(cls_sel) == CLS_MEM) ? fetch_mem : fetch_br;
    raw[P_MISS]  = dmiss;
    raw[P_USE]   = rd_vld & rd_pend;
    raw[P_EXT]   = ext_sig;
  end

  assign trig_vec = raw & pol_en;
  assign trig_any = |trig_vec;
endmodule

// File: rtl/tsw_rr_pick.sv
module tsw_rr_pick #(
  parameter int NTHR = 4,
  localparam int TW = $clog2(NTHR)
) (
  input  logic [TW-1:0]   act,
  input  logic [NTHR-1:0] elig,
  output logic [TW-1:0]   nxt,
  output logic            found
);
  function automatic logic [TW:0] rr_next(input logic [TW-1:0] cur,
                                          input logic [NTHR-1:0] ok);
    logic [TW:0] res;
    res = {1'b0, cur};
    for (int k = NTHR - 1; k >= 1; k--) begin
      int idx;
      idx = (int'(cur) + k) % NTHR;
      if (ok[idx]) res = {1'b1, TW'(idx)};
    end
    return res;
  endfunction

  assign {found, nxt} = rr_next(act, elig);
endmodule

// File: rtl/tswitch_ctrl.sv
module tswitch_ctrl
  import tsw_pkg::*;
#(
  parameter int NTHR = 4,
  parameter int NREG = 8,
  parameter int PCW  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [4:0]                pol_en,
  input  logic                      cls_sel,
  input  logic                      sw_instr,
  input  logic                      fetch_mem,
  input  logic                      fetch_br,
  input  logic                      dmiss,
  input  logic                      ext_sig,
  input  logic                      rd_vld,
  input  logic [$clog2(NREG)-1:0]   rd_reg,
  input  logic                      ld_iss,
  input  logic [$clog2(NTHR)-1:0]   ld_iss_thr,
  input  logic [$clog2(NREG)-1:0]   ld_iss_reg,
  input  logic                      ld_ret,
  input  logic [$clog2(NTHR)-1:0]   ld_ret_thr,
  input  logic [$clog2(NREG)-1:0]   ld_ret_reg,
  input  logic [NTHR-1:0]           thr_ready,
  input  logic [PCW-1:0]            cur_pc,
  output logic [$clog2(NTHR)-1:0]   act_thr,
  output logic                      sw_strobe,
  output logic                      flush,
  output logic [PCW-1:0]            restart_pc
);
  localparam int TW = $clog2(NTHR);

  logic                   rd_pend;
  logic [NTHR-1:0]        pend_any;
  logic [NTHR*NREG-1:0]   vld_flat;
  logic [NPOL-1:0]        trig_vec;
  logic                   trig_any;
  logic [NTHR-1:0]        elig;
  logic [TW-1:0]          pick_thr;
  logic                   pick_found;
  logic                   sw_go;

  tsw_scoreboard #(.NTHR(NTHR), .NREG(NREG)) u_sb (
    .clk(clk), .rst_n(rst_n),
    .ld_iss(ld_iss), .ld_iss_thr(ld_iss_thr), .ld_iss_reg(ld_iss_reg),
    .ld_ret(ld_ret), .ld_ret_thr(ld_ret_thr), .ld_ret_reg(ld_ret_reg),
    .rd_thr(act_thr), .rd_reg(rd_reg), .rd_pend(rd_pend),
    .pend_any(pend_any), .vld_flat(vld_flat)
  );

  tsw_trigger u_trig (
    .cls_sel(cls_sel), .pol_en(pol_en), .sw_instr(sw_instr),
    .fetch_mem(fetch_mem), .fetch_br(fetch_br), .dmiss(dmiss),
    .ext_sig(ext_sig), .rd_vld(rd_vld), .rd_pend(rd_pend),
    .trig_vec(trig_vec), .trig_any(trig_any)
  );

  for (genvar t = 0; t < NTHR; t++) begin : g_elig
    assign elig[t] = thr_ready[t] & ~pend_any[t] & (act_thr != TW'(t));
  end

  tsw_rr_pick #(.NTHR(NTHR)) u_pick (
    .act(act_thr), .elig(elig), .nxt(pick_thr), .found(pick_found)
  );

  assign sw_go = trig_any & pick_found;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_thr    <= '0;
      sw_strobe  <= 1'b0;
      flush      <= 1'b0;
      restart_pc <= '0;
    end else begin
      sw_strobe <= sw_go;
      flush     <= sw_go;
      if (sw_go) begin
        act_thr    <= pick_thr;
        restart_pc <= cur_pc;
      end
    end
  end
endmodule

// File: rtl/tsw_chk.sv
module tsw_chk #(
  parameter int NTHR = 4,
  parameter int NREG = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      trig_any,
  input logic                      pick_found,
  input logic                      sw_go,
  input logic [$clog2(NTHR)-1:0]   act_thr,
  input logic                      sw_strobe,
  input logic                      flush,
  input logic                      ld_iss,
  input logic [$clog2(NTHR)-1:0]   ld_iss_thr,
  input logic [$clog2(NREG)-1:0]   ld_iss_reg,
  input logic                      ld_ret,
  input logic [$clog2(NTHR)-1:0]   ld_ret_thr,
  input logic [$clog2(NREG)-1:0]   ld_ret_reg,
  input logic [NTHR*NREG-1:0]      vld_flat
);
  int iss_idx, ret_idx;
  assign iss_idx = int'(ld_iss_thr) * NREG + int'(ld_iss_reg);
  assign ret_idx = int'(ld_ret_thr) * NREG + int'(ld_ret_reg);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_any |=> $stable(act_thr));

  p_stay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_any && !pick_found) |=> ($stable(act_thr) && !sw_strobe));

  p_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_strobe |-> (act_thr != $past(act_thr)));

  p_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush == sw_strobe);

  p_go_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_go |=> sw_strobe);

  p_iss_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_iss |=> !vld_flat[$past(iss_idx)]);

  p_ret_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ret && !(ld_iss && iss_idx == ret_idx)) |=> vld_flat[$past(ret_idx)]);
endmodule

bind tswitch_ctrl tsw_chk #(.NTHR(NTHR), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_any(trig_any), .pick_found(pick_found),
  .sw_go(sw_go), .act_thr(act_thr), .sw_strobe(sw_strobe), .flush(flush),
  .ld_iss(ld_iss), .ld_iss_thr(ld_iss_thr), .ld_iss_reg(ld_iss_reg),
  .ld_ret(ld_ret), .ld_ret_thr(ld_ret_thr), .ld_ret_reg(ld_ret_reg),
  .vld_flat(vld_flat)
);

// File: tb/tswitch_ctrl_tb.sv
`timescale 1ns/1ps
module tswitch_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  pol_en;
  logic        cls_sel, sw_instr, fetch_mem, fetch_br, dmiss, ext_sig, rd_vld;
  logic [2:0]  rd_reg;
  logic        ld_iss, ld_ret;
  logic [1:0]  ld_iss_thr, ld_ret_thr;
  logic [2:0]  ld_iss_reg, ld_ret_reg;
  logic [3:0]  thr_ready;
  logic [31:0] cur_pc;
  logic [1:0]  act_thr;
  logic        sw_strobe, flush;
  logic [31:0] restart_pc;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tswitch_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pol_en(pol_en), .cls_sel(cls_sel),
    .sw_instr(sw_instr), .fetch_mem(fetch_mem), .fetch_br(fetch_br),
    .dmiss(dmiss), .ext_sig(ext_sig), .rd_vld(rd_vld), .rd_reg(rd_reg),
    .ld_iss(ld_iss), .ld_iss_thr(ld_iss_thr), .ld_iss_reg(ld_iss_reg),
    .ld_ret(ld_ret), .ld_ret_thr(ld_ret_thr), .ld_ret_reg(ld_ret_reg),
    .thr_ready(thr_ready), .cur_pc(cur_pc), .act_thr(act_thr),
    .sw_strobe(sw_strobe), .flush(flush), .restart_pc(restart_pc)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_sw(input string req, input int exp_thr, input bit exp_sw);
    chk(act_thr == 2'(exp_thr), req, int'(act_thr), exp_thr);
    chk(sw_strobe == exp_sw, req, int'(sw_strobe), int'(exp_sw));
    chk(flush == exp_sw, req, int'(flush), int'(exp_sw));
  endtask

  task automatic idle();
    sw_instr = 0; fetch_mem = 0; fetch_br = 0; dmiss = 0; ext_sig = 0;
    rd_vld = 0; ld_iss = 0; ld_ret = 0;
  endtask

  // round-robin pick restated: offsets 1..3 from cur, first ready wins
  function automatic int mdl_next(input int cur, input logic [3:0] rdy, output bit fnd);
    fnd = 0;
    for (int k = 1; k < 4; k++) begin
      int c;
      c = (cur + k) % 4;
      if (rdy[c]) begin fnd = 1; return c; end
    end
    return cur;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pol_en = 5'h1F; cls_sel = 0; rd_reg = 0;
    ld_iss_thr = 0; ld_iss_reg = 0; ld_ret_thr = 0; ld_ret_reg = 0;
    thr_ready = 4'hF; cur_pc = 0;
    idle();
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state and hold
    chk_sw("R1 reset", 0, 0);
    repeat (3) tick();
    chk_sw("R1 hold", 0, 0);

    // R2 explicit, R10 pulse and restart pc
    sw_instr = 1; cur_pc = 32'h100; tick();
    chk_sw("R2 explicit", 1, 1);
    chk(restart_pc == 32'h100, "R10 restart_pc", int'(restart_pc), 32'h100);
    idle(); cur_pc = 32'h200; tick();
    chk_sw("R10 one-cycle pulse", 1, 0);
    chk(restart_pc == 32'h100, "R10 restart_pc held", int'(restart_pc), 32'h100);
    pol_en = 5'h1E; sw_instr = 1; tick();
    chk_sw("R2 explicit disabled", 1, 0);
    idle(); pol_en = 5'h1F;

    // R3 fetch class
    cls_sel = 0; fetch_br = 1; tick();
    chk_sw("R3 branch ignored in memory class", 1, 0);
    idle(); fetch_mem = 1; tick();
    chk_sw("R3 memory class", 2, 1);
    idle(); cls_sel = 1; fetch_mem = 1; tick();
    chk_sw("R3 memory ignored in branch class", 2, 0);
    idle(); fetch_br = 1; tick();
    chk_sw("R3 branch class", 3, 1);
    idle();

    // R4 miss, R5 external
    dmiss = 1; tick();
    chk_sw("R4 cache miss", 0, 1);
    idle(); ext_sig = 1; tick();
    chk_sw("R5 external", 1, 1);
    idle();

    // R6/R7 switch on use, active = 1
    ld_iss = 1; ld_iss_thr = 1; ld_iss_reg = 3; tick();
    chk_sw("R7 load issue alone", 1, 0);
    idle(); rd_vld = 1; rd_reg = 5; tick();
    chk_sw("R7 read of valid reg", 1, 0);
    pol_en = 5'h17; rd_reg = 3; tick();
    chk_sw("R7 use trigger disabled", 1, 0);
    pol_en = 5'h1F; tick();
    chk_sw("R7 read of pending reg", 2, 1);
    idle();

    // R8 skip pending thread 1
    sw_instr = 1; tick(); chk_sw("R8 rr 2->3", 3, 1);
    tick(); chk_sw("R8 rr 3->0", 0, 1);
    tick(); chk_sw("R8 skip pending thread", 2, 1);
    idle(); ld_ret = 1; ld_ret_thr = 1; ld_ret_reg = 3; tick();
    chk_sw("R6 return alone no switch", 2, 0);
    idle(); sw_instr = 1;
    tick(); chk_sw("R6 after return 2->3", 3, 1);
    tick(); chk_sw("R6 after return 3->0", 0, 1);
    tick(); chk_sw("R6 returned thread eligible", 1, 1);
    idle();

    // R6 same-cycle issue and return: issue wins, thread 2 pending
    ld_iss = 1; ld_iss_thr = 2; ld_iss_reg = 0;
    ld_ret = 1; ld_ret_thr = 2; ld_ret_reg = 0; tick();
    idle(); sw_instr = 1; tick();
    chk_sw("R6 issue beats return", 3, 1);
    idle(); ld_ret = 1; ld_ret_thr = 2; ld_ret_reg = 0; tick();
    idle();

    // R9 nobody else ready
    thr_ready = 4'b1000; sw_instr = 1; tick();
    chk_sw("R9 no eligible thread", 3, 0);
    thr_ready = 4'b0000; tick();
    chk_sw("R9 none ready", 3, 0);
    idle();

    // R8 sweep over every ready mask, four triggers each
    begin
      int cur;
      cur = 3;
      sw_instr = 1;
      for (int m = 0; m < 16; m++) begin
        for (int i = 0; i < 4; i++) begin
          int e;
          bit f;
          thr_ready = 4'(m);
          cur_pc = 32'(m * 16 + i);
          e = mdl_next(cur, 4'(m), f);
          tick();
          chk_sw("R8 sweep", e, f);
          if (f) chk(restart_pc == 32'(m * 16 + i), "R10 sweep restart_pc",
                     int'(restart_pc), m * 16 + i);
          cur = e;
        end
      end
      idle();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule